// File: doc/BRIEF.md
# Memory Test Data Pattern Generator

This block supplies one data word per beat to a memory traffic tester. A 4-bit pattern code selects what appears on the data output. The patterns are an incrementing count, a pseudo-random sequence from a linear feedback shift register, a single set bit that walks, a single cleared bit that walks, and two patterns that toggle the whole word between all ones and all zeros. All pattern engines step together on every advance strobe. The pattern code only picks which engine drives the output, so the code can change between beats without losing position in any sequence.

Software can store shift-register start values in a small bank of seed slots. Each write names a slot number and carries the value. A separate slot selector chooses which stored value the random engine loads. A restart pulse returns every engine to its start state. A read checker can therefore run a second copy of the block, restart it, and get back exactly the word sequence that the writer produced.

Top module: `mtp_gen`

## Requirements
- R1: After synchronous reset, the output in each mode shows the start state. Linear is 0. PRBS holds 1, seen as the register bits repeated across the word. Walking-one is 1, walking-zero is all ones except bit 0, hammer-one is all ones and hammer-zero is all zeros. The error flag is low.
- R2: Mode code 0 selects linear. Its count starts at 0, goes up by one per advance and wraps to 0 after 2^DATA_W - 1.
- R3: Mode code 1 selects PRBS. The register shifts left once per advance, with feedback as follows. Order 8 uses x^8+x^6+x^5+x^4+1, so fb = s[7]^s[5]^s[4]^s[3]. Order 10 uses x^10+x^7+1, so fb = s[9]^s[6]. Order 23 uses x^23+x^18+1, so fb = s[22]^s[17]. The next state is {s[ORDER-2:0], fb}, and output bit i equals s[i mod ORDER].
- R4: Mode code 2 outputs a single 1 that starts at bit 0 and rotates left one position per advance, from the top bit back to bit 0. Mode code 3 outputs the bitwise inverse of that word.
- R5: Mode code 4 toggles between all ones and all zeros on each advance, starting with all ones. Mode code 5 is its inverse and starts with all zeros.
- R6: Mode codes 6 to 15 are reserved. In any of them the output is all zeros and the error flag is high, in the same cycle the code is applied.
- R7: Without advance or restart, no engine changes. All engines step on every advance, whatever the mode.
- R8: Restart returns every engine to its start state on the next clock edge. When restart and advance come in the same cycle, restart wins.
- R9: When the seed-write enable is high and the slot number is below NUM_SEEDS, the slot stores the seed value. Slot numbers of NUM_SEEDS or more are ignored. The selected slot is loaded only on restart. A write to the selected slot in the same cycle as restart loads the new value. A selector of NUM_SEEDS or more uses slot 0. All slots reset to 1.
- R10: A PRBS seed of zero is loaded as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Pattern code |
| seed_wr_en | input | 1 | Seed slot write enable |
| seed_wr_idx | input | 8 | Slot number written |
| seed_wr_val | input | PRBS_ORDER | Seed value written |
| seed_sel | input | 8 | Slot loaded by restart |
| advance | input | 1 | Step all engines one beat |
| restart | input | 1 | Return all engines to start state |
| data_out | output | DATA_W | Pattern word |
| mode_err | output | 1 | Reserved code applied |

## Verification
Two pairs of functions can collide in one cycle. Restart can arrive together with advance, and restart can arrive together with a seed write to the slot it is about to load. The bench first drives advance for several beats. It then raises restart and advance together and expects the count to read zero rather than one. Next it writes a fresh seed to the selected slot in the same cycle as restart. It expects the PRBS word to show the new seed, not the stored one, on the following beat.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    typedef enum logic [3:0] {
        PAT_LINEAR = 4'd0,
        PAT_PRBS   = 4'd1,
        PAT_WALK1  = 4'd2,
        PAT_WALK0  = 4'd3,
        PAT_HAM1   = 4'd4,
        PAT_HAM0   = 4'd5
    } pat_mode_e;

    localparam int unsigned LAST_LEGAL_CODE = 5;

    typedef struct packed {
        logic       load;   // return to start state
        logic       step;   // advance one beat
    } eng_ctl_t;

    function automatic logic pat_reserved(input logic [3:0] code);
        return int'(code) > LAST_LEGAL_CODE;
    endfunction

    function automatic eng_ctl_t make_ctl(input logic restart, input logic advance);
        eng_ctl_t c;
        c.load = restart;
        c.step = advance & ~restart;
        return c;
    endfunction

endpackage

// File: rtl/mtp_seed_bank.sv
module mtp_seed_bank #(
    parameter int SEED_W    = 23,
    parameter int NUM_SEEDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [SEED_W-1:0] wr_val,
    input  logic [7:0]        sel,
    output logic [SEED_W-1:0] seed
);
    localparam int SLOT_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;

    logic [SEED_W-1:0] slots [NUM_SEEDS];
    logic              wr_ok;
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;

    assign wr_ok   = wr_en && (int'(wr_idx) < NUM_SEEDS);
    assign wr_slot = wr_idx[SLOT_W-1:0];
    assign rd_slot = (int'(sel) < NUM_SEEDS) ? sel[SLOT_W-1:0] : '0;

    genvar g;
    generate
        for (g = 0; g < NUM_SEEDS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slots[g] <= SEED_W'(1);
                end else if (wr_ok && (int'(wr_slot) == g)) begin
                    slots[g] <= wr_val;
                end
            end
        end
    endgenerate

    // same-cycle write to the slot being read is forwarded
    always_comb begin
        if (wr_ok && (wr_slot == rd_slot)) begin
            seed = wr_val;
        end else begin
            seed = slots[rd_slot];
        end
    end

endmodule

// File: rtl/mtp_prbs.sv
module mtp_prbs
    import mtp_pkg::*;
#(
    parameter int ORDER  = 23,
    parameter int DATA_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  eng_ctl_t         ctl,
    input  logic [ORDER-1:0] seed,
    output logic [DATA_W-1:0] word
);
    logic [ORDER-1:0] state;
    logic [ORDER-1:0] seed_fix;
    logic             fb;

    generate
        if (ORDER == 8) begin : g_o8
            assign fb = state[7] ^ state[5] ^ state[4] ^ state[3];
        end else if (ORDER == 10) begin : g_o10
            assign fb = state[9] ^ state[6];
        end else begin : g_o23
            assign fb = state[22] ^ state[17];
        end
    endgenerate

    assign seed_fix = (seed == '0) ? ORDER'(1) : seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ORDER'(1);
        end else if (ctl.load) begin
            state <= seed_fix;
        end else if (ctl.step) begin
            state <= {state[ORDER-2:0], fb};
        end
    end

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_rep
            assign word[i] = state[i % ORDER];
        end
    endgenerate

endmodule

// File: rtl/mtp_simple_eng.sv
module mtp_simple_eng
    import mtp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  eng_ctl_t          ctl,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] walk_word,
    output logic              phase
);
    localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(DATA_W - 1);

    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst || ctl.load) begin
            count <= '0;
            pos   <= '0;
            phase <= 1'b0;
        end else if (ctl.step) begin
            count <= count + DATA_W'(1);
            pos   <= (pos == POS_LAST) ? '0 : pos + POS_W'(1);
            phase <= ~phase;
        end
    end

    assign walk_word = {{(DATA_W-1){1'b0}}, 1'b1} << pos;

endmodule

// File: rtl/mtp_gen.sv
module mtp_gen
    import mtp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PRBS_ORDER = 23,
    parameter int NUM_SEEDS  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [3:0]            mode,
    input  logic                  seed_wr_en,
    input  logic [7:0]            seed_wr_idx,
    input  logic [PRBS_ORDER-1:0] seed_wr_val,
    input  logic [7:0]            seed_sel,
    input  logic                  advance,
    input  logic                  restart,
    output logic [DATA_W-1:0]     data_out,
    output logic                  mode_err
);
    eng_ctl_t              ctl;
    logic [PRBS_ORDER-1:0] seed;
    logic [DATA_W-1:0]     prbs_word;
    logic [DATA_W-1:0]     count;
    logic [DATA_W-1:0]     walk_word;
    logic                  phase;

    assign ctl = make_ctl(restart, advance);

    mtp_seed_bank #(.SEED_W(PRBS_ORDER), .NUM_SEEDS(NUM_SEEDS)) u_seeds (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (seed_wr_en),
        .wr_idx (seed_wr_idx),
        .wr_val (seed_wr_val),
        .sel    (seed_sel),
        .seed   (seed)
    );

    mtp_prbs #(.ORDER(PRBS_ORDER), .DATA_W(DATA_W)) u_prbs (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .seed (seed),
        .word (prbs_word)
    );

    mtp_simple_eng #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .count     (count),
        .walk_word (walk_word),
        .phase     (phase)
    );

    always_comb begin
        mode_err = pat_reserved(mode);
        case (pat_mode_e'(mode))
            PAT_LINEAR: data_out = count;
            PAT_PRBS:   data_out = prbs_word;
            PAT_WALK1:  data_out = walk_word;
            PAT_WALK0:  data_out = ~walk_word;
            PAT_HAM1:   data_out = {DATA_W{~phase}};
            PAT_HAM0:   data_out = {DATA_W{phase}};
            default:    data_out = '0;
        endcase
    end

endmodule

// File: rtl/mtp_gen_chk.sv
module mtp_gen_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        mode,
    input logic              advance,
    input logic              restart,
    input logic [DATA_W-1:0] data_out,
    input logic              mode_err
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode > 4'd5) |-> (data_out == '0 && mode_err)); // R6

    AST_LEGAL_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (mode <= 4'd5) |-> !mode_err); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!advance && !restart) |=> (mode != $past(mode)) || $stable(data_out)); // R7

    AST_RESTART_COUNT: assert property (@(posedge clk) disable iff (rst)
        restart |=> (mode != 4'd0) || (data_out == '0)); // R8

    AST_WALK1_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd2) |-> ($countones(data_out) == 1)); // R4

    AST_WALK0_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd3) |-> ($countones(~data_out) == 1)); // R4

    AST_HAMMER_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd4 && advance && !restart) |=>
            (mode != 4'd4) || (data_out == ~$past(data_out))); // R5

endmodule

bind mtp_gen mtp_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .advance  (advance),
    .restart  (restart),
    .data_out (data_out),
    .mode_err (mode_err)
);

// File: tb/tb_mtp_gen.sv
module tb_mtp_gen;
    localparam int DW = 12;
    localparam int PO = 10;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    mode = '0;
    logic          seed_wr_en = 1'b0;
    logic [7:0]    seed_wr_idx = '0;
    logic [PO-1:0] seed_wr_val = '0;
    logic [7:0]    seed_sel = '0;
    logic          advance = 1'b0;
    logic          restart = 1'b0;
    logic [DW-1:0] data_out;
    logic          mode_err;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mtp_gen #(.DATA_W(DW), .PRBS_ORDER(PO), .NUM_SEEDS(NS)) dut (
        .clk(clk), .rst(rst), .mode(mode),
        .seed_wr_en(seed_wr_en), .seed_wr_idx(seed_wr_idx),
        .seed_wr_val(seed_wr_val), .seed_sel(seed_sel),
        .advance(advance), .restart(restart),
        .data_out(data_out), .mode_err(mode_err)
    );

    // {err, mode, expected word}; entry k is checked after k advances
    localparam logic [16:0] VEC [13] = '{
        {1'b0, 4'd0, 12'h000},
        {1'b0, 4'd2, 12'h002},
        {1'b0, 4'd3, 12'hFFB},
        {1'b0, 4'd4, 12'h000},
        {1'b0, 4'd5, 12'h000},
        {1'b0, 4'd5, 12'hFFF},
        {1'b0, 4'd0, 12'h006},
        {1'b1, 4'd9, 12'h000},
        {1'b0, 4'd2, 12'h100},
        {1'b0, 4'd3, 12'hDFF},
        {1'b0, 4'd4, 12'hFFF},
        {1'b0, 4'd2, 12'h800},
        {1'b0, 4'd2, 12'h001}
    };

    task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic beat();
        @(negedge clk);
    endtask

    task automatic pulse_adv();
        advance = 1'b1; beat(); advance = 1'b0;
    endtask

    task automatic pulse_restart();
        restart = 1'b1; beat(); restart = 1'b0;
    endtask

    function automatic logic [PO-1:0] lfsr_next(input logic [PO-1:0] s);
        return {s[PO-2:0], s[9] ^ s[6]};
    endfunction

    function automatic logic [DW-1:0] expand(input logic [PO-1:0] s);
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = s[i % PO];
        return w;
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [PO-1:0] s;
        beat(); beat();
        rst = 1'b0;
        beat();

        // R1 reset state
        mode = 4'd0; #1 chk("R1 linear", {mode_err, data_out}, 13'h0000);
        mode = 4'd1; #1 chk("R1 prbs",   {mode_err, data_out}, {1'b0, 12'h401});
        mode = 4'd2; #1 chk("R1 walk1",  {mode_err, data_out}, {1'b0, 12'h001});
        mode = 4'd3; #1 chk("R1 walk0",  {mode_err, data_out}, {1'b0, 12'hFFE});
        mode = 4'd4; #1 chk("R1 ham1",   {mode_err, data_out}, {1'b0, 12'hFFF});
        mode = 4'd5; #1 chk("R1 ham0",   {mode_err, data_out}, {1'b0, 12'h000});

        // table walk: R2 R4 R5 R6 R7
        for (int k = 0; k < 13; k++) begin
            mode = VEC[k][15:12];
            #1 chk("R2/R4/R5/R6 table", {mode_err, data_out}, {VEC[k][16], VEC[k][11:0]});
            beat();
            #1 chk("R7 hold idle", {mode_err, data_out}, {VEC[k][16], VEC[k][11:0]});
            pulse_adv();
        end

        // R6 top reserved code
        mode = 4'd15; #1 chk("R6 code15", {mode_err, data_out}, {1'b1, 12'h000});

        // R2 wrap
        mode = 4'd0;
        pulse_restart();
        advance = 1'b1;
        repeat (4095) beat();
        advance = 1'b0;
        chk("R2 max", {mode_err, data_out}, {1'b0, 12'hFFF});
        pulse_adv();
        chk("R2 wrap", {mode_err, data_out}, {1'b0, 12'h000});

        // R8 restart beats advance
        pulse_adv(); pulse_adv(); pulse_adv();
        advance = 1'b1; restart = 1'b1; beat();
        advance = 1'b0; restart = 1'b0;
        chk("R8 restart wins", {mode_err, data_out}, {1'b0, 12'h000});

        // R9 seed write and R3 sequence
        mode = 4'd1;
        seed_wr_en = 1'b1; seed_wr_idx = 8'd1; seed_wr_val = 10'h2A5; beat();
        seed_wr_en = 1'b0;
        seed_sel = 8'd1;
        #1 chk("R9 no load before restart", {mode_err, data_out}, {1'b0, 12'h401});
        pulse_restart();
        chk("R9 seed loaded", {mode_err, data_out}, {1'b0, 12'h6A5});
        s = 10'h2A5;
        for (int k = 0; k < 20; k++) begin
            pulse_adv();
            s = lfsr_next(s);
            chk("R3 prbs step", {mode_err, data_out}, {1'b0, expand(s)});
        end

        // R10 zero seed
        seed_wr_en = 1'b1; seed_wr_idx = 8'd2; seed_wr_val = '0; beat();
        seed_wr_en = 1'b0; seed_sel = 8'd2;
        pulse_restart();
        chk("R10 zero seed", {mode_err, data_out}, {1'b0, 12'h401});

        // R9 out-of-range slot ignored, out-of-range select uses slot 0
        seed_wr_en = 1'b1; seed_wr_idx = 8'd9; seed_wr_val = 10'h155; beat();
        seed_wr_en = 1'b0; seed_sel = 8'd9;
        pulse_restart();
        chk("R9 bad slot ignored", {mode_err, data_out}, {1'b0, 12'h401});

        // R9 write in same cycle as restart to selected slot
        seed_sel = 8'd3;
        seed_wr_en = 1'b1; seed_wr_idx = 8'd3; seed_wr_val = 10'h0F3; restart = 1'b1;
        beat();
        seed_wr_en = 1'b0; restart = 1'b0;
        chk("R9 bypass", {mode_err, data_out}, {1'b0, expand(10'h0F3)});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule